// File: doc/BRIEF.md
# Integer ALU with Signed Overflow Trap

This block is the integer execute stage of a load/store RISC pipeline. Each cycle it takes two register operands, an operation code, a 16-bit immediate, and shift controls. One clock edge later it presents the registered result. It also presents an overflow flag and a matching write-inhibit flag. The pipeline uses the write-inhibit flag to keep the destination register unchanged when a signed add or subtract traps.

The operations are add and subtract, each in a trapping and a non-trapping form. The block also does the four bitwise functions, signed and unsigned set-on-less-than, three shifts and load-upper-immediate. When the immediate replaces operand B, the operation code sets how it is widened. Arithmetic and compare codes sign-extend it, including the unsigned ones. The four bitwise codes zero-extend it. Shifts act on operand A. The shift distance comes either from a constant field or from the low bits of register operand B.

Top module: `int_alu_top`

## Requirements
- R1: Codes 0 (ADD) and 2 (SUB) produce A+B and A-B modulo 2^32. The overflow flag is set when the exact signed result does not fit in 32 bits. For add, that means both operands have the same sign and the result's sign differs. For subtract, it means the operands differ in sign and the result's sign differs from A.
- R2: Codes 1 (ADDU) and 3 (SUBU) produce the same wrapped sums as codes 0 and 2, and never set the overflow flag.
- R3: Code 8 (SLT) returns 1 if A < B as two's complement numbers. Code 9 (SLTU) returns 1 if A < B as unsigned numbers. Both return 0 otherwise, so bits 31:1 are always zero.
- R4: The bitwise codes are 4 (A AND B), 5 (A OR B), 6 (A XOR B) and 7 (NOT (A OR B)).
- R5: The shift codes are 10 (logical left), 11 (logical right, zero fill) and 12 (arithmetic right, fill with A[31]). All three shift operand A. When `shift_var_i`=0 the distance is `shamt_i`. When `shift_var_i`=1 the distance is bits 4:0 of register input `b_i`, and its upper bits are ignored.
- R6: With `b_imm_i`=1, operand B becomes the widened immediate. Codes 0-3, 8 and 9 sign-extend it. Codes 4-7 zero-extend it.
- R7: Code 13 (LUI) returns the immediate in bits 31:16 with bits 15:0 cleared.
- R8: `wr_inhibit_o` equals the overflow flag in every cycle. Both can be 1 only for codes 0 and 2.
- R9: Outputs are registered with a latency of one clock. A synchronous active-high reset clears the result and both flags.
- R10: Reserved codes 14 and 15 return 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Register operand A |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate field |
| b_imm_i | input | 1 | 1: operand B is the widened immediate |
| shamt_i | input | 5 | Constant shift distance |
| shift_var_i | input | 1 | 1: shift distance from b_i[4:0] |
| res_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered overflow trap |
| wr_inhibit_o | output | 1 | Registered destination write inhibit |

## Verification
The bench builds the block with its default widths: a 32-bit datapath, a 16-bit immediate and a 5-bit shift distance. At 32 bits, the operand values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF sit exactly on the signed and unsigned wrap points, so the overflow rule and the difference between the two compares can be hit directly. With the 16-bit immediate, 0xFFFF and 0x8000 show whether the immediate is sign-extended or zero-extended. With the 5-bit distance, register values above 31 test that only the low bits set the shift.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDU = 4'd1,  OP_SUB = 4'd2,  OP_SUBU = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR = 4'd6,  OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,  OP_SLTU = 4'd9,  OP_SLL = 4'd10, OP_SRL  = 4'd11,
    OP_SRA  = 4'd12, OP_LUI  = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } alu_op_e;

  // bitwise group widens its immediate with zeros
  function automatic logic op_is_bitwise(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction

  // adder runs in subtract mode for these
  function automatic logic op_uses_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  // only the signed add/sub forms may trap
  function automatic logic op_traps(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   b_reg,
  input  logic [IMM_W-1:0]    imm,
  input  logic                b_imm,
  input  logic [SHAMT_W-1:0]  shamt,
  input  logic                shift_var,
  output logic [DATA_W-1:0]   b_eff,
  output logic [SHAMT_W-1:0]  sh_amt
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext, imm_zext;

  assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign imm_zext = {{EXT_W{1'b0}}, imm};

  always_comb begin
    if (!b_imm)                 b_eff = b_reg;
    else if (op_is_bitwise(op)) b_eff = imm_zext;
    else                        b_eff = imm_sext;
  end

  // variable distance uses only the low bits of the register operand
  assign sh_amt = shift_var ? b_reg[SHAMT_W-1:0] : shamt;
endmodule

// File: rtl/alu_adder_unit.sv
module alu_adder_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e            op,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  sum,
  output logic               lt_signed,
  output logic               lt_unsigned,
  output logic               ovf_trap
);
  localparam int MSB = DATA_W - 1;

  logic              do_sub;
  logic [DATA_W-1:0] b_x;
  logic [DATA_W:0]   wide;
  logic              ovf_raw;

  assign do_sub = op_uses_sub(op);
  assign b_x    = do_sub ? ~b : b;
  assign wide   = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, do_sub};
  assign sum    = wide[MSB:0];

  // equal-sign addends whose sum flips sign cannot be represented
  assign ovf_raw  = (a[MSB] == b_x[MSB]) && (sum[MSB] != a[MSB]);
  assign ovf_trap = ovf_raw && op_traps(op);

  assign lt_unsigned = ~wide[DATA_W];
  assign lt_signed   = (a[MSB] ^ b[MSB]) ? a[MSB] : sum[MSB];
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [IMM_W-1:0]    imm,
  input  logic [SHAMT_W-1:0]  sh_amt,
  output logic [DATA_W-1:0]   logic_res,
  output logic [DATA_W-1:0]   shift_res,
  output logic [DATA_W-1:0]   lui_res
);
  localparam int LOW_W = DATA_W - IMM_W;

  logic                        left, fill;
  logic [DATA_W-1:0]           a_rev, out_rev, shin;
  logic [SHAMT_W:0][DATA_W-1:0] stg;

  always_comb begin
    unique case (op)
      OP_AND:  logic_res = a & b;
      OP_OR:   logic_res = a | b;
      OP_XOR:  logic_res = a ^ b;
      default: logic_res = ~(a | b);
    endcase
  end

  assign left = (op == OP_SLL);
  assign fill = (op == OP_SRA) && a[DATA_W-1];

  // left shift reuses the right shifter on bit-reversed data
  always_comb begin
    for (int i = 0; i < DATA_W; i++) a_rev[i] = a[DATA_W-1-i];
  end
  assign shin   = left ? a_rev : a;
  assign stg[0] = shin;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = sh_amt[k] ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) out_rev[i] = stg[SHAMT_W][DATA_W-1-i];
  end
  assign shift_res = left ? out_rev : stg[SHAMT_W];

  assign lui_res = {imm, {LOW_W{1'b0}}};
endmodule

// File: rtl/int_alu_top.sv
module int_alu_top
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         op_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic               b_imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               shift_var_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               ovf_o,
  output logic               wr_inhibit_o
);
  alu_op_e            op;
  logic [DATA_W-1:0]  b_eff, sum, logic_res, shift_res, lui_res, res_d;
  logic [SHAMT_W-1:0] sh_amt;
  logic               lt_s, lt_u, trap;

  assign op = alu_op_e'(op_i);

  alu_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_prep (
    .op(op), .b_reg(b_i), .imm(imm_i), .b_imm(b_imm_i), .shamt(shamt_i),
    .shift_var(shift_var_i), .b_eff(b_eff), .sh_amt(sh_amt)
  );

  alu_adder_unit #(.DATA_W(DATA_W)) u_add (
    .op(op), .a(a_i), .b(b_eff), .sum(sum), .lt_signed(lt_s),
    .lt_unsigned(lt_u), .ovf_trap(trap)
  );

  alu_logic_shift #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)) u_ls (
    .op(op), .a(a_i), .b(b_eff), .imm(imm_i), .sh_amt(sh_amt),
    .logic_res(logic_res), .shift_res(shift_res), .lui_res(lui_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: res_d = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    res_d = logic_res;
      OP_SLT:                           res_d = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:                          res_d = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:           res_d = shift_res;
      OP_LUI:                           res_d = lui_res;
      default:                          res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o        <= '0;
      ovf_o        <= 1'b0;
      wr_inhibit_o <= 1'b0;
    end else begin
      res_o        <= res_d;
      ovf_o        <= trap;
      wr_inhibit_o <= trap;
    end
  end

  // R2: unsigned and non-arithmetic codes never trap
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !op_traps(alu_op_e'($past(op_i)))) |-> !ovf_o);

  // R3: compare results are a single bit
  p_cmp_bool_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU))
      |-> (res_o[DATA_W-1:1] == '0));

  // R7: upper-immediate load leaves the low half clear
  p_lui_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_LUI)
      |-> (res_o == {$past(imm_i), {(DATA_W-IMM_W){1'b0}}}));

  // R8: inhibit and overflow agree
  p_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
    wr_inhibit_o == ovf_o);

  // R9: reset leaves a cleared output stage
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && !ovf_o && !wr_inhibit_o));

  // R10: reserved codes yield zero
  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 4'd14) |-> (res_o == '0 && !ovf_o));
endmodule

// File: tb/tb_int_alu_top.sv
module tb_int_alu_top;
  localparam real CLK_NS = 8.0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic        b_imm_i = 1'b0, shift_var_i = 1'b0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] res_o;
  logic        ovf_o, wr_inhibit_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t sb[$];
  bit   done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  int_alu_top dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .b_imm_i(b_imm_i), .shamt_i(shamt_i), .shift_var_i(shift_var_i),
    .res_o(res_o), .ovf_o(ovf_o), .wr_inhibit_o(wr_inhibit_o)
  );

  // independent reference from the requirements
  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] br,
                                 logic [15:0] imm, logic bi, logic [4:0] sa, logic sv);
    exp_t e;
    logic [31:0] b;
    logic [4:0]  d;
    logic [32:0] t;
    e.res = '0; e.ovf = 1'b0; e.tag = "";
    if (!bi) b = br;
    else if (op >= 4 && op <= 7) b = {16'h0, imm};
    else b = {{16{imm[15]}}, imm};
    d = sv ? br[4:0] : sa;
    case (op)
      0, 1: begin
        e.res = a + b;
        if (op == 0) e.ovf = (a[31] == b[31]) && (e.res[31] != a[31]);
      end
      2, 3: begin
        e.res = a - b;
        if (op == 2) e.ovf = (a[31] != b[31]) && (e.res[31] != a[31]);
      end
      4: e.res = a & b;
      5: e.res = a | b;
      6: e.res = a ^ b;
      7: e.res = ~(a | b);
      8: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      9: begin t = {1'b0, a} - {1'b0, b}; e.res = {31'd0, t[32]}; end
      10: e.res = a << d;
      11: e.res = a >> d;
      12: e.res = $unsigned($signed(a) >>> d);
      13: e.res = {imm, 16'h0};
      default: e.res = '0;
    endcase
    return e;
  endfunction

  task automatic drive(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm, input logic bi,
                       input logic [4:0] sa, input logic sv);
    exp_t e;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; imm_i = imm; b_imm_i = bi; shamt_i = sa; shift_var_i = sv;
    e = model(op, a, b, imm, bi, sa, sv);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: result for the item pushed before an edge appears after it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        n_tests++;
        if (res_o !== e.res || ovf_o !== e.ovf || wr_inhibit_o !== e.ovf) begin
          n_fail++;
          $display("FAIL %s: actual res=%h ovf=%b inh=%b expected res=%h ovf=%b inh=%b",
                   e.tag, res_o, ovf_o, wr_inhibit_o, e.res, e.ovf, e.ovf);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    op_i = 4'd0; a_i = 32'h7FFF_FFFF; b_i = 32'd1;
    repeat (3) @(posedge clk);
    #2;
    n_tests++;
    if (res_o !== 32'd0 || ovf_o !== 1'b0 || wr_inhibit_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: actual res=%h ovf=%b expected res=0 ovf=0", res_o, ovf_o);
    end
    @(negedge clk); rst = 1'b0;

    // R1 signed add/sub and overflow boundaries
    drive("R1 add small",      0, 32'd5, 32'd7, 16'h0, 0, 0, 0);
    drive("R1 add overflow",   0, 32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 0);
    drive("R1 add neg ovf",    0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 0, 0, 0);
    drive("R1 sub overflow",   2, 32'h8000_0000, 32'd1, 16'h0, 0, 0, 0);
    drive("R1 sub no ovf",     2, 32'd3, 32'd10, 16'h0, 0, 0, 0);
    drive("R1 sub pos ovf",    2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 0, 0);
    // R2 unsigned forms wrap without trap
    drive("R2 addu wrap",      1, 32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 0);
    drive("R2 subu wrap",      3, 32'h8000_0000, 32'd1, 16'h0, 0, 0, 0);
    // R6 immediate widening
    drive("R6 add imm sext",   0, 32'd100, 32'hDEAD, 16'hFFFF, 1, 0, 0);
    drive("R6 addu imm sext",  1, 32'd0, 32'd0, 16'h8000, 1, 0, 0);
    drive("R6 and imm zext",   4, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 1, 0, 0);
    drive("R6 or imm zext",    5, 32'h1234_0000, 32'd0, 16'h8001, 1, 0, 0);
    drive("R6 sltu imm sext",  9, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 1, 0, 0);
    // R4 bitwise
    drive("R4 xor",            6, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 0, 0, 0);
    drive("R4 nor",            7, 32'h0000_00F0, 32'h0F00_000F, 16'h0, 0, 0, 0);
    drive("R4 and",            4, 32'hAAAA_5555, 32'hFF00_FF00, 16'h0, 0, 0, 0);
    // R3 compares
    drive("R3 slt neg<pos",    8, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 0);
    drive("R3 sltu big<1",     9, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 0, 0);
    drive("R3 slt extremes",   8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, 0);
    drive("R3 sltu equal",     9, 32'd42, 32'd42, 16'h0, 0, 0, 0);
    // R5 shifts
    drive("R5 sll const",     10, 32'h8000_0001, 32'd0, 16'h0, 0, 5'd4, 0);
    drive("R5 srl var low5",  11, 32'hF000_0000, 32'h0000_0025, 16'h0, 0, 5'd0, 1);
    drive("R5 sra neg",       12, 32'h8000_0000, 32'd0, 16'h0, 0, 5'd31, 0);
    drive("R5 sra var pos",   12, 32'h4000_0000, 32'hFFFF_FFE3, 16'h0, 0, 5'd9, 1);
    // R7 upper immediate
    drive("R7 lui",           13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 1, 0, 0);
    // R10 reserved
    drive("R10 reserved 14",  14, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'hFFFF, 0, 0, 0);
    drive("R10 reserved 15",  15, 32'h7FFF_FFFF, 32'd1, 16'h0, 0, 0, 0);

    // R8 mixed traffic: inhibit must follow overflow every cycle
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 7 == 0) ra = 32'h7FFF_FFFF;
      if (i % 11 == 0) rb = 32'h8000_0000;
      drive("R8 mixed", 4'($urandom_range(15)), ra, rb, 16'($urandom()),
            1'($urandom_range(1)), 5'($urandom()), 1'($urandom_range(1)));
    end

    @(negedge clk);
    op_i = 4'd14;
    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule